// File: doc/BRIEF.md
# Mode-Register Burst Column Sequencer

This block keeps the settings that a mode-register-set command loads: how many beats a burst carries, whether the column order is linear or bit-flipped, the read latency in clocks, and the DLL-reset and test-mode requests. A command decoder pulses `mode_wr` with the 12-bit opcode taken from the address bus. When a read or write begins, it pulses `start` with the 9-bit start column. From then on, each `advance` pulse moves the block to the next column of the burst.

`col` always shows the column of the current beat. `last_beat` marks the final beat. A write that carries an undefined length or latency code raises a sticky error flag, and the block keeps the last good value of that field. Bursts always stay inside the aligned group of columns whose size equals the burst length.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the outputs are: `col` = 0, `last_beat` = 0, `cas_lat` = 3, both error flags 0, `dll_rst` = 0 and `test_en` = 0. The burst is 2 beats in linear order.
- R2: Opcode bits [2:0] set the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8.
- R3: When opcode bit 3 is 0, the order is linear. Each beat adds one to the low log2(length) bits of the start column, wrapping within that field. The higher bits keep the start value.
- R4: When opcode bit 3 is 1, the order is interleaved. The column of beat k is the start column with its low log2(length) bits XORed with k.
- R5: Opcode bits [6:4] set `cas_lat`: 3'b011 gives 3 and 3'b100 gives 4.
- R6: A mode write whose bits [2:0] are not 001, 010 or 011 sets `bl_err`. The flag stays set until reset, and the burst length keeps its previous value.
- R7: A mode write whose bits [6:4] are not 011 or 100 sets `cl_err`. The flag stays set until reset, and `cas_lat` keeps its previous value.
- R8: Each mode write loads `dll_rst` with (bit 8 AND NOT bit 7) and loads `test_en` with bit 7.
- R9: `last_beat` is high exactly on beat length−1. An `advance` on the last beat ends the burst: `last_beat` drops and `col` holds. An `advance` outside a burst has no effect.
- R10: `start` loads `start_col` into `col` on the next edge and restarts at beat 0, even in the middle of a burst. When `start` and `advance` arrive together, `start` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Load the mode fields from `mode_op` |
| mode_op | input | 12 | Mode opcode |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | Start column |
| advance | input | 1 | Step to the next beat |
| col | output | 9 | Column of the current beat |
| last_beat | output | 1 | Current beat is the final one |
| cas_lat | output | 3 | Decoded read latency in clocks |
| bl_err | output | 1 | Sticky flag for an undefined length code |
| cl_err | output | 1 | Sticky flag for an undefined latency code |
| dll_rst | output | 1 | DLL reset requested |
| test_en | output | 1 | Test mode selected |

## Verification
The sequence table covers every length in both orders. Its start columns are chosen so that each order gives a different sequence. For example, an interleaved 4-beat burst from offset 01 gives 1,0,3,2, while a linear one gives 1,2,3,0. This separates XOR from add and catches a mask of the wrong width. A linear 8-beat burst starting at 0x1FF shows whether the wrap carries into the upper column bits. Directed tests cover undefined codes mixed with good ones, restarts in the middle of a burst, start and advance arriving together, and stray advances while no burst is running.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9,
  parameter int OP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [OP_W-1:0]  mode_op,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             advance,
  output logic [COL_W-1:0] col,
  output logic             last_beat,
  output logic [2:0]       cas_lat,
  output logic             bl_err,
  output logic             cl_err,
  output logic             dll_rst,
  output logic             test_en
);

  logic [1:0]       len_sel;
  logic             ilv;
  logic [COL_W-1:0] base;
  logic [2:0]       beat;
  logic             active;

  logic [2:0] mask, nxt, low_seq, low_ilv, low_new;
  logic       op_len_ok, op_cl_ok;

  assign mask      = {len_sel == 2'd3, len_sel >= 2'd2, 1'b1};
  assign nxt       = beat + 3'd1;
  assign low_seq   = (base[2:0] + nxt) & mask;
  assign low_ilv   = (base[2:0] ^ nxt) & mask;
  assign low_new   = (base[2:0] & ~mask) | (ilv ? low_ilv : low_seq);
  assign last_beat = active && (beat == mask);

  assign op_len_ok = (mode_op[2:0] != 3'd0) && (mode_op[2:0] <= 3'd3);
  assign op_cl_ok  = (mode_op[6:4] == 3'd3) || (mode_op[6:4] == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_sel <= 2'd1;
      ilv     <= 1'b0;
      cas_lat <= 3'd3;
      bl_err  <= 1'b0;
      cl_err  <= 1'b0;
      dll_rst <= 1'b0;
      test_en <= 1'b0;
    end else if (mode_wr) begin
      ilv     <= mode_op[3];
      dll_rst <= mode_op[8] & ~mode_op[7];
      test_en <= mode_op[7];
      if (op_len_ok) len_sel <= mode_op[1:0];
      else           bl_err  <= 1'b1;
      if (op_cl_ok)  cas_lat <= mode_op[6:4];
      else           cl_err  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      col    <= '0;
      beat   <= '0;
      active <= 1'b0;
    end else if (start) begin
      base   <= start_col;
      col    <= start_col;
      beat   <= '0;
      active <= 1'b1;
    end else if (advance && active) begin
      if (last_beat) begin
        active <= 1'b0;
        beat   <= '0;
      end else begin
        beat <= nxt;
        col  <= {base[COL_W-1:3], low_new};
      end
    end
  end

endmodule

module burst_col_gen_chk #(
  parameter int COL_W = 9,
  parameter int OP_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [OP_W-1:0]  mode_op,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             advance,
  input logic [COL_W-1:0] col,
  input logic             last_beat,
  input logic [2:0]       cas_lat,
  input logic             bl_err,
  input logic             cl_err,
  input logic             dll_rst,
  input logic             test_en
);

  // R5
  cas_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'd3) || (cas_lat == 3'd4));

  // R6
  bl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !(mode_op[2:0] inside {3'd1, 3'd2, 3'd3})) |=> bl_err);

  // R6
  bl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bl_err |=> bl_err);

  // R7
  cl_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !(mode_op[6:4] inside {3'd3, 3'd4})) |=> cl_err);

  // R7
  cl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cl_err |=> cl_err);

  // R8
  dll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (dll_rst == ($past(mode_op[8]) && !$past(mode_op[7]))) && (test_en == $past(mode_op[7])));

  // R3
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !start) |=> col[COL_W-1:3] == $past(col[COL_W-1:3]));

  // R9
  end_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && advance && !start) |=> !last_beat && $stable(col));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col == $past(start_col)) && !last_beat);

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W), .OP_W(OP_W)) u_chk (.*);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [11:0] mode_op = '0;
  logic        start = 1'b0;
  logic [8:0]  start_col = '0;
  logic        advance = 1'b0;
  logic [8:0]  col;
  logic        last_beat;
  logic [2:0]  cas_lat;
  logic        bl_err, cl_err, dll_rst, test_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen u_burst_col_gen (.*);

  localparam logic [11:0] V_OP [NV] = '{12'h031, 12'h032, 12'h033, 12'h03A, 12'h04B, 12'h039, 12'h033};
  localparam logic [8:0]  V_ST [NV] = '{9'h0A5, 9'h0A6, 9'h10D, 9'h0A5, 9'h1FB, 9'h000, 9'h1FF};
  localparam int          V_BL [NV] = '{2, 4, 8, 4, 8, 2, 8};
  localparam int          V_CL [NV] = '{3, 3, 3, 3, 4, 3, 3};
  localparam logic [8:0]  V_EX [NV][8] = '{
    '{9'h0A5, 9'h0A4, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h0A6, 9'h0A7, 9'h0A4, 9'h0A5, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h10D, 9'h10E, 9'h10F, 9'h108, 9'h109, 9'h10A, 9'h10B, 9'h10C},
    '{9'h0A5, 9'h0A4, 9'h0A7, 9'h0A6, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h1FB, 9'h1FA, 9'h1F9, 9'h1F8, 9'h1FF, 9'h1FE, 9'h1FD, 9'h1FC},
    '{9'h000, 9'h001, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h1FF, 9'h1F8, 9'h1F9, 9'h1FA, 9'h1FB, 9'h1FC, 9'h1FD, 9'h1FE}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mode(input logic [11:0] op);
    mode_wr = 1'b1; mode_op = op; tick(); mode_wr = 1'b0;
  endtask

  task automatic go(input logic [8:0] c);
    start = 1'b1; start_col = c; tick(); start = 1'b0;
  endtask

  task automatic step();
    advance = 1'b1; tick(); advance = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 col", col, 0);
    chk("R1 last", last_beat, 0);
    chk("R1 cas", cas_lat, 3);
    chk("R1 err", {bl_err, cl_err, dll_rst, test_en}, 0);
    rst_n = 1'b1; tick();
    // R1 default 2-beat linear
    go(9'h003);
    chk("R1 b0", col, 9'h003);
    chk("R1 b0 last", last_beat, 0);
    step();
    chk("R1 b1", col, 9'h002);
    chk("R1 b1 last", last_beat, 1);
    step();

    // R2 R3 R4 R5 R9 table walk
    for (int v = 0; v < NV; v++) begin
      mode(V_OP[v]);
      chk("R5 cas", cas_lat, V_CL[v]);
      go(V_ST[v]);
      for (int b = 0; b < V_BL[v]; b++) begin
        chk(V_OP[v][3] ? "R4 col" : "R3 col", col, V_EX[v][b]);
        chk("R2 R9 last", last_beat, (b == V_BL[v] - 1) ? 1 : 0);
        if (b < V_BL[v] - 1) step();
      end
      step();
      chk("R9 ended", last_beat, 0);
      chk("R9 hold", col, V_EX[v][V_BL[v] - 1]);
    end

    // R9 advance while idle
    step();
    chk("R9 idle col", col, 9'h1FE);
    chk("R9 idle last", last_beat, 0);

    // R6 reserved length, keeps 8
    mode(12'h034);
    chk("R6 flag", bl_err, 1);
    chk("R6 cl ok", cl_err, 0);
    go(9'h010);
    for (int b = 0; b < 3; b++) step();
    chk("R6 keep len", last_beat, 0);
    for (int b = 0; b < 4; b++) step();
    chk("R6 keep len last", last_beat, 1);
    chk("R6 col", col, 9'h017);
    step();

    // R7 reserved latency, keeps 4
    mode(12'h043);
    chk("R5 cas4", cas_lat, 4);
    mode(12'h073);
    chk("R7 flag", cl_err, 1);
    chk("R7 keep", cas_lat, 4);
    mode(12'h032);
    chk("R6 sticky", bl_err, 1);
    chk("R7 sticky", cl_err, 1);
    chk("R7 valid again", cas_lat, 3);

    // R8 mode control bits
    mode(12'h132);
    chk("R8 dll", dll_rst, 1);
    chk("R8 test", test_en, 0);
    mode(12'h1B2);
    chk("R8 both dll", dll_rst, 0);
    chk("R8 both test", test_en, 1);
    mode(12'h032);
    chk("R8 clear", {dll_rst, test_en}, 0);

    // R10 restart mid-burst (4-beat linear)
    go(9'h040);
    step(); step();
    chk("R10 mid", col, 9'h042);
    go(9'h055);
    chk("R10 restart col", col, 9'h055);
    step(); step(); step();
    chk("R10 beat0 again", last_beat, 1);
    chk("R10 col", col, 9'h054);
    // R10 start beats advance
    start = 1'b1; advance = 1'b1; start_col = 9'h123; tick();
    start = 1'b0; advance = 1'b0;
    chk("R10 priority col", col, 9'h123);
    chk("R10 priority last", last_beat, 0);
    step();
    chk("R10 next", col, 9'h120);

    finish_up();
  end
endmodule